// File: doc/BRIEF.md
# Oscillator Divider with Periodic Trim

This block sits in a watch-crystal divider chain. It counts oscillator ticks and emits a one-cycle enable at the end of every second. It trims the rate by changing the length of a few selected seconds: it does not reprogram the divisor. The divider has two stages. A prescaler divides by `PRE_DIV` (256 by default) and a post stage divides by `POST_DIV` (128 by default), so a plain second is `PRE_DIV*POST_DIV` ticks.

The trim setting is a `MAG_W`-bit magnitude N and a sign. Trimming runs on a repeating cycle of `2^(MAG_W+1)` minutes, each `SEC_PER_MIN` seconds long. In the first 2×N minutes of the cycle, the first second of the minute is altered:
- A positive sign drops one whole prescaler period, so the clock runs faster.
- A negative sign stretches the first prescaler period of that second by half a period, so the clock runs slower.

The block also carries the least significant bit of the seconds register. When frequency test is enabled, it replaces that bit with a square wave that toggles every `FT_HALF` oscillator ticks. The square wave does not depend on the trim setting.

Top module: `rtc_trim_div`

## Requirements
- R1: While reset is held, `sec_tick_o` is 0 and the test wave is 0. The first second after reset is `PRE_DIV*POST_DIV` ticks long.
- R2: With magnitude 0 in effect, every second is exactly `PRE_DIV*POST_DIV` ticks long, whatever the sign.
- R3: `sec_tick_o` is high only in a clock where `osc_tick_i` is high. It marks the tick that completes the second and lasts one clock.
- R4: With sign 1 and magnitude N in effect, the first second of cycle minutes 0 to 2N-1 is `PRE_DIV*(POST_DIV-1)` ticks long.
- R5: With sign 0 and magnitude N in effect, the first second of cycle minutes 0 to 2N-1 is `PRE_DIV*POST_DIV + PRE_DIV/2` ticks long.
- R6: Every other second is `PRE_DIV*POST_DIV` ticks long. This covers the seconds after the first one in any minute, and every second of cycle minutes 2N and above.
- R7: The minute index advances only at the end of a minute and wraps after `2^(MAG_W+1)` minutes. The trim pattern then repeats from cycle minute 0.
- R8: `cal_mag_i` and `cal_sign_i` are sampled only at the tick that ends a minute, and govern the next minute. The setting in effect during minute 0 after reset is magnitude 0.
- R9: While `ftest_i` is 1, `sec_lsb_o` equals the test wave. The wave starts at 0 after reset and inverts in the clock after every `FT_HALF`-th oscillator tick, counted from reset, independently of the trim setting.
- R10: While `ftest_i` is 0, `sec_lsb_o` equals `sec_lsb_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| osc_tick_i | input | 1 | One-clock pulse per oscillator cycle |
| cal_mag_i | input | MAG_W | Trim magnitude N |
| cal_sign_i | input | 1 | Trim sign: 1 faster, 0 slower |
| ftest_i | input | 1 | Frequency-test select |
| sec_lsb_i | input | 1 | Seconds-register LSB from the calendar |
| sec_tick_o | output | 1 | Second-complete enable |
| sec_lsb_o | output | 1 | Seconds LSB or test wave |

## Verification
`sec_tick_o` is combinational on the registered count. It is therefore due in the same clock as the oscillator tick that completes the second. The test wave is registered and changes one clock after the tick that triggers it. The bench drives every input just after a falling edge. It samples one nanosecond before the next rising edge, so each tick is paired with the outputs it produces before any state moves. A trim setting is credited in the bench model only at the second-end sample where the design latches it.

// File: rtl/rtc_trim_pkg.sv
package rtc_trim_pkg;
  typedef enum logic [1:0] {
    ADJ_NONE  = 2'd0,
    ADJ_SHORT = 2'd1,
    ADJ_LONG  = 2'd2
  } adj_e;
endpackage

// File: rtl/rtc_trim_prescale.sv
module rtc_trim_prescale #(
  parameter int unsigned PRE_DIV = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic stretch_i,
  output logic stage_o
);
  localparam int unsigned LONG_LEN = PRE_DIV + PRE_DIV / 2;
  localparam int unsigned CW = $clog2(LONG_LEN);
  localparam logic [CW-1:0] LAST_N = CW'(PRE_DIV - 1);
  localparam logic [CW-1:0] LAST_L = CW'(LONG_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic at_end;

  assign at_end  = (cnt_q == (stretch_i ? LAST_L : LAST_N));
  assign stage_o = tick_i & at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/rtc_trim_seq.sv
module rtc_trim_seq
  import rtc_trim_pkg::*;
#(
  parameter int unsigned POST_DIV    = 128,
  parameter int unsigned SEC_PER_MIN = 60,
  parameter int unsigned MAG_W       = 5,
  localparam int unsigned MIN_W      = MAG_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stage_i,
  input  logic [MAG_W-1:0] cal_mag_i,
  input  logic             cal_sign_i,
  output logic             stretch_o,
  output logic             sec_tick_o,
  output logic [MIN_W-1:0] min_idx_o
);
  localparam int unsigned POST_W = $clog2(POST_DIV);
  localparam int unsigned SEC_W  = $clog2(SEC_PER_MIN);
  localparam logic [POST_W-1:0] POST_LAST_N = POST_W'(POST_DIV - 1);
  localparam logic [POST_W-1:0] POST_LAST_S = POST_W'(POST_DIV - 2);
  localparam logic [SEC_W-1:0]  SEC_LAST    = SEC_W'(SEC_PER_MIN - 1);

  logic [POST_W-1:0] post_q;
  logic [SEC_W-1:0]  sec_q;
  logic [MIN_W-1:0]  min_q;
  logic [MAG_W-1:0]  act_mag_q;
  logic              act_sign_q;
  adj_e              kind;
  logic [POST_W-1:0] post_last;
  logic              sec_end;

  // first second of an early cycle minute is the trimmed one
  always_comb begin
    kind = ADJ_NONE;
    if (sec_q == '0 && min_q < {act_mag_q, 1'b0})
      kind = act_sign_q ? ADJ_SHORT : ADJ_LONG;
  end

  assign post_last  = (kind == ADJ_SHORT) ? POST_LAST_S : POST_LAST_N;
  assign sec_end    = stage_i & (post_q == post_last);
  assign stretch_o  = (kind == ADJ_LONG) & (post_q == '0);
  assign sec_tick_o = sec_end;
  assign min_idx_o  = min_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      post_q     <= '0;
      sec_q      <= '0;
      min_q      <= '0;
      act_mag_q  <= '0;
      act_sign_q <= 1'b0;
    end else if (sec_end) begin
      post_q <= '0;
      if (sec_q == SEC_LAST) begin
        sec_q      <= '0;
        min_q      <= min_q + 1'b1;
        act_mag_q  <= cal_mag_i;
        act_sign_q <= cal_sign_i;
      end else begin
        sec_q <= sec_q + 1'b1;
      end
    end else if (stage_i) begin
      post_q <= post_q + 1'b1;
    end
  end
endmodule

// File: rtl/rtc_trim_ftgen.sv
module rtc_trim_ftgen #(
  parameter int unsigned FT_HALF = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic wave_o
);
  localparam int unsigned FW = $clog2(FT_HALF);
  localparam logic [FW-1:0] FT_LAST = FW'(FT_HALF - 1);

  logic [FW-1:0] cnt_q;
  logic          wave_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else if (tick_i) begin
      if (cnt_q == FT_LAST) begin
        cnt_q  <= '0;
        wave_q <= ~wave_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign wave_o = wave_q;
endmodule

// File: rtl/rtc_trim_div.sv
module rtc_trim_div #(
  parameter int unsigned PRE_DIV     = 256,
  parameter int unsigned POST_DIV    = 128,
  parameter int unsigned SEC_PER_MIN = 60,
  parameter int unsigned MAG_W       = 5,
  parameter int unsigned FT_HALF     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             osc_tick_i,
  input  logic [MAG_W-1:0] cal_mag_i,
  input  logic             cal_sign_i,
  input  logic             ftest_i,
  input  logic             sec_lsb_i,
  output logic             sec_tick_o,
  output logic             sec_lsb_o
);
  localparam int unsigned MIN_W = MAG_W + 1;

  logic             stage;
  logic             stretch;
  logic             ft_wave;
  logic [MIN_W-1:0] min_idx;

  rtc_trim_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (osc_tick_i),
    .stretch_i (stretch),
    .stage_o   (stage)
  );

  rtc_trim_seq #(
    .POST_DIV    (POST_DIV),
    .SEC_PER_MIN (SEC_PER_MIN),
    .MAG_W       (MAG_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stage_i    (stage),
    .cal_mag_i  (cal_mag_i),
    .cal_sign_i (cal_sign_i),
    .stretch_o  (stretch),
    .sec_tick_o (sec_tick_o),
    .min_idx_o  (min_idx)
  );

  rtc_trim_ftgen #(.FT_HALF(FT_HALF)) u_ft (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (osc_tick_i),
    .wave_o (ft_wave)
  );

  assign sec_lsb_o = ftest_i ? ft_wave : sec_lsb_i;
endmodule

// File: rtl/rtc_trim_div_chk.sv
module rtc_trim_div_chk #(
  parameter int unsigned PRE_DIV  = 256,
  parameter int unsigned POST_DIV = 128,
  parameter int unsigned MIN_W    = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             osc_tick_i,
  input logic             sec_tick_o,
  input logic             ft_wave_i,
  input logic [MIN_W-1:0] min_idx_i
);
  localparam int unsigned MIN_LEN = PRE_DIV * (POST_DIV - 1);
  localparam int unsigned MAX_LEN = PRE_DIV * POST_DIV + PRE_DIV / 2;
  localparam int unsigned SW = $clog2(MAX_LEN + 1) + 1;

  logic [SW-1:0] span_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         span_q <= '0;
    else if (sec_tick_o) span_q <= '0;
    else if (osc_tick_i) span_q <= span_q + 1'b1;
  end

  // R3
  sec_on_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> osc_tick_i);

  // R3
  sec_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |=> !sec_tick_o);

  // R6
  span_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_tick_o |-> ((32'(span_q) + 1 >= MIN_LEN) && (32'(span_q) + 1 <= MAX_LEN)));

  // R6
  span_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(span_q) < MAX_LEN);

  // R9
  ft_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_tick_i |=> $stable(ft_wave_i));

  // R7
  min_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sec_tick_o |=> $stable(min_idx_i));
endmodule

bind rtc_trim_div rtc_trim_div_chk #(
  .PRE_DIV  (PRE_DIV),
  .POST_DIV (POST_DIV),
  .MIN_W    (MAG_W + 1)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .osc_tick_i (osc_tick_i),
  .sec_tick_o (sec_tick_o),
  .ft_wave_i  (ft_wave),
  .min_idx_i  (min_idx)
);

// File: tb/rtc_trim_div_bench.sv
module rtc_trim_div_bench;
  localparam int PRE = 8;
  localparam int POST = 4;
  localparam int SPM = 3;
  localparam int MW = 2;
  localparam int FTH = 2;
  localparam int CYC = 1 << (MW + 1);
  localparam int NORM = PRE * POST;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic osc_tick = 1'b0;
  logic [MW-1:0] cal_mag = '0;
  logic cal_sign = 1'b0;
  logic ftest = 1'b0;
  logic lsb_in = 1'b0;
  logic sec_tick;
  logic lsb_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // bench-side drive values, applied just after a falling edge
  int nxt_mag = 0;
  bit nxt_sign = 0;
  bit nxt_ft = 0;

  // model state
  int k = 0;
  int tick_cnt = 0;
  int tick_total = 0;
  int act_mag = 0;
  bit act_sign = 0;
  int r8_min = 0;

  always #2 clk = ~clk;

  rtc_trim_div #(
    .PRE_DIV(PRE), .POST_DIV(POST), .SEC_PER_MIN(SPM), .MAG_W(MW), .FT_HALF(FTH)
  ) u_rtc_trim_div (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(osc_tick), .cal_mag_i(cal_mag),
    .cal_sign_i(cal_sign), .ftest_i(ftest), .sec_lsb_i(lsb_in),
    .sec_tick_o(sec_tick), .sec_lsb_o(lsb_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (second %0d)", tag, act, exp, k);
    end
  endtask

  task automatic observe();
    int exp_len;
    int s;
    int mn;
    int m;
    bit adj;
    string tag;
    bit exp_ft;
    exp_ft = ((tick_total / FTH) % 2) == 1;
    if (ftest) chk(lsb_out == exp_ft, "R9", int'(lsb_out), int'(exp_ft));
    else       chk(lsb_out == lsb_in, "R10", int'(lsb_out), int'(lsb_in));
    if (sec_tick && !osc_tick) chk(0, "R3", 1, 0);
    if (osc_tick) begin
      tick_cnt++;
      tick_total++;
    end
    if (sec_tick) begin
      s  = k % SPM;
      mn = k / SPM;
      m  = mn % CYC;
      adj = (s == 0) && (m < 2 * act_mag);
      if (adj) exp_len = act_sign ? PRE * (POST - 1) : NORM + PRE / 2;
      else     exp_len = NORM;
      if (s == 0 && mn == r8_min)        tag = "R8";
      else if (k == 0)                   tag = "R1";
      else if (adj && m == 0 && mn >= CYC) tag = "R7";
      else if (adj)                      tag = act_sign ? "R4" : "R5";
      else if (s == 0 && act_mag == 0)   tag = "R2";
      else                               tag = "R6";
      chk(tick_cnt == exp_len, tag, tick_cnt, exp_len);
      if (s == SPM - 1) begin
        act_mag  = int'(cal_mag);
        act_sign = cal_sign;
      end
      k++;
      tick_cnt = 0;
    end
  endtask

  task automatic step(input bit tk);
    @(negedge clk);
    osc_tick = tk;
    cal_mag  = nxt_mag[MW-1:0];
    cal_sign = nxt_sign;
    ftest    = nxt_ft;
    lsb_in   = tick_total[2] ^ tick_total[0];
    #1;
    observe();
  endtask

  task automatic run_secs(input int n, input int gap);
    int target;
    target = k + n;
    while (k < target) begin
      for (int g = 1; g < gap; g++) step(1'b0);
      step(1'b1);
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R3 watchdog actual=%0d expected=%0d", k, -1);
      finish_run();
    end
  end

  initial begin
    // R1: reset state with a nonzero setting and test mode already applied
    cal_mag = 2'd3; cal_sign = 1'b1; ftest = 1'b1;
    nxt_mag = 3; nxt_sign = 1; nxt_ft = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(sec_tick == 1'b0, "R1", int'(sec_tick), 0);
    chk(lsb_out == 1'b0, "R1", int'(lsb_out), 0);
    @(negedge clk);
    rst_n = 1'b1;
    // minute 0 must run untrimmed (R8), later minutes shortened
    run_secs(2 * SPM, 1);
    r8_min = -1;
    // sweep every sign and magnitude over more than a full cycle
    for (int sg = 1; sg >= 0; sg--) begin
      for (int mg = 0; mg < (1 << MW); mg++) begin
        nxt_mag = mg; nxt_sign = bit'(sg); nxt_ft = bit'(mg % 2);
        run_secs(SPM * CYC + SPM, (mg == 2) ? 3 : 1);
      end
    end
    // R8: change mid-minute, effective from the next minute
    while (k % SPM != 1) step(1'b1);
    nxt_mag = 2; nxt_sign = 0; nxt_ft = 1;
    r8_min = k / SPM + 1;
    run_secs(2 * SPM, 2);
    nxt_mag = 0; nxt_sign = 1; nxt_ft = 0;
    run_secs(2 * SPM + 1, 1);
    finish_run();
  end
endmodule